// File: doc/BRIEF.md
# SPI Master/Slave Serial Port

This block is a byte-wide SPI port that a host bus controls through three addressed registers: a data register, a control register and a status register. One shift engine serves both roles. As master, the block generates SCK from the system clock through a power-of-two divider. It drives SDO and samples SDI, and it can drive an active-low chip select. As slave, it follows an external SCK and an optional external chip select. It brings both into the system clock domain through synchronisers before it shifts.

The control byte sets the following. Bit 7 is the enable. Bit 6 selects master (1) or slave (0). Bit 5 is the clock polarity. Bit 4 selects LSB-first. Bit 3 is the chip-select enable. Bits 2:0 are the divider exponent. The status byte has three flags. Bit 0 is transfer complete. Bit 1 is busy. Bit 2 is write collision, which is cleared by writing 1 to it. Address 0 is data, 1 is control, 2 is status, and address 3 reads as zero. Pin drivers are modelled as separate value and output-enable signals, so an output enable of 0 means the pin is tri-stated.

Top module: `spi_port`

## Requirements
- R1: After reset the data, control and status registers read 0, and sck_oe, sdo_oe and scs_oe are 0.
- R2: In master mode with the enable set, a data write while idle loads the byte and sets busy (status bit 1). SCK then makes 16 edges, each 2^div system cycles apart. Busy reads 1 for exactly 16*2^div cycles, and it clears in the same cycle that transfer complete (status bit 0) sets.
- R3: Control bit 4 at 1 shifts the LSB out first and takes the first received bit as the LSB. At 0, the MSB goes first.
- R4: Control bit 5 at 1 makes SCK idle low, with data sampled on rising edges and changed on falling edges. At 0, SCK idles high, data is sampled on falling edges and changed on rising edges.
- R5: At completion the received byte replaces the data register, and a read of address 0 returns it.
- R6: In master mode with chip-select enable (bit 3) set, scs_oe is 1 and scs_o is 0 exactly while busy. With bit 3 clear, scs_oe is 0.
- R7: In slave mode the port shifts on synchronised edges of sck_i. After the 8th data-changing edge, the received byte is in the data register and transfer complete is set.
- R8: In slave mode with chip-select enable set, SCK edges while scs_i is high are ignored and sdo_oe is 0. With chip-select enable clear, scs_i has no effect.
- R9: A data write while busy sets the sticky write-collision flag (status bit 2). The written byte is discarded, the shift in progress is unchanged, and only a status write with bit 2 at 1 clears the flag.
- R10: A read of address 0, or an accepted data write, clears transfer complete.
- R11: Clearing the enable bit aborts any transfer, returns all three status flags to 0 and drops all three output enables.
- R12: When a transfer completes in the same cycle as a data read or a data write, completion wins: transfer complete reads 1, and the write counts as a collision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address: 0 data, 1 control, 2 status |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effects only; read data is combinational) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| sck_i | input | 1 | Serial clock in (slave) |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe | output | 1 | Serial clock output enable |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial data output enable |
| scs_i | input | 1 | Active-low chip select in (slave) |
| scs_o | output | 1 | Active-low chip select out (master) |
| scs_oe | output | 1 | Chip select output enable |

## Verification
The end of a transfer can land in the same system cycle as a host access to the data register. That access can be a read, which clears the complete flag, or a write, which tests for a collision. In master mode the end of a transfer falls exactly 16*2^div cycles after the starting write. The bench counts those cycles and places the read or the write on that very edge. The outcome is judged from the status and data registers: complete must read 1 and busy 0, a write must have raised the collision flag, and the data register must hold the received byte rather than the written one.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned DIV_W  = 3;

    localparam int unsigned STAT_DONE = 0;
    localparam int unsigned STAT_BUSY = 1;
    localparam int unsigned STAT_WCOL = 2;

    typedef enum logic [1:0] {
        ADDR_DATA = 2'd0,
        ADDR_CTRL = 2'd1,
        ADDR_STAT = 2'd2,
        ADDR_NONE = 2'd3
    } addr_e;

    typedef struct packed {
        logic             en;
        logic             master;
        logic             cpol;
        logic             lsb_first;
        logic             cs_en;
        logic [DIV_W-1:0] div;
    } ctrl_t;

endpackage

// File: rtl/spi_port_sync.sv
module spi_port_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] st_d, st_q;

    always_comb begin
        st_d = {st_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= {STAGES{RST_VAL}};
        else        st_q <= st_d;
    end

    assign q = st_q[STAGES-1];
endmodule

// File: rtl/spi_port_baud.sv
module spi_port_baud #(
    parameter int unsigned DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int unsigned CNT_W = (1 << DIV_W) - 1;

    logic [CNT_W-1:0] cnt_d, cnt_q, limit;

    always_comb begin
        limit = (CNT_W'(1) << div) - CNT_W'(1);
        tick  = run && (cnt_q == limit);
        cnt_d = (!run || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi_port_engine.sv
module spi_port_engine
    import spi_port_pkg::*;
#(
    parameter int unsigned BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  ctrl_t           ctrl,
    input  logic            load,
    input  logic [BITS-1:0] load_data,
    input  logic            tick,
    input  logic            sck_in,
    input  logic            sel_ok,
    input  logic            sdi,
    output logic            busy,
    output logic            done,
    output logic [BITS-1:0] rx_data,
    output logic            sck_lvl,
    output logic            sdo
);
    localparam int unsigned EDGES  = 2 * BITS;
    localparam int unsigned EDGE_W = $clog2(EDGES);

    typedef struct packed {
        logic [BITS-1:0]   sh;
        logic              rxbit;
        logic [EDGE_W-1:0] edges;
        logic              busy;
        logic              sck;
        logic              sck_prev;
    } eng_t;

    eng_t q, n;
    logic lead, trail, idle_lvl;
    logic [BITS-1:0] shifted;

    always_comb begin
        n        = q;
        lead     = 1'b0;
        trail    = 1'b0;
        done     = 1'b0;
        idle_lvl = ~ctrl.cpol;
        shifted  = ctrl.lsb_first ? {q.rxbit, q.sh[BITS-1:1]}
                                  : {q.sh[BITS-2:0], q.rxbit};
        n.sck_prev = sck_in;

        if (ctrl.master) begin
            if (q.busy && tick) begin
                n.sck = ~q.sck;
                lead  = ~q.edges[0];
                trail = q.edges[0];
            end
        end else if (sel_ok && (sck_in != q.sck_prev)) begin
            lead  = (sck_in == ctrl.cpol) && !q.edges[0];
            trail = (sck_in != ctrl.cpol) && q.edges[0];
        end

        if (lead) begin
            n.rxbit = sdi;
            n.busy  = 1'b1;
            n.edges = q.edges + 1'b1;
        end
        if (trail) begin
            n.sh    = shifted;
            n.edges = q.edges + 1'b1;
            if (q.edges == EDGE_W'(EDGES - 1)) begin
                n.edges = '0;
                n.busy  = 1'b0;
                done    = ctrl.en;
            end
        end

        if (!ctrl.master && !sel_ok) begin
            n.edges = '0;
            n.busy  = 1'b0;
        end

        if (load) begin
            n.sh    = load_data;
            n.edges = '0;
            n.busy  = ctrl.master;
        end

        if (!n.busy) n.sck = idle_lvl;

        if (!ctrl.en) begin
            n.edges = '0;
            n.busy  = 1'b0;
            n.sck   = idle_lvl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign busy    = q.busy;
    assign rx_data = shifted;
    assign sck_lvl = q.sck;
    assign sdo     = ctrl.lsb_first ? q.sh[0] : q.sh[BITS-1];

    // R2: a running master clock only moves on a divider tick
    assert_sck_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.en && ctrl.master && q.busy && !tick && !load) |=> $stable(q.sck));

endmodule

// File: rtl/spi_port.sv
module spi_port
    import spi_port_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              sck_i,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              sdi_i,
    output logic              sdo_o,
    output logic              sdo_oe,
    input  logic              scs_i,
    output logic              scs_o,
    output logic              scs_oe
);
    localparam int unsigned PAD_W = DATA_W - 3;

    typedef struct packed {
        ctrl_t             ctrl;
        logic [DATA_W-1:0] data;
        logic              done;
        logic              wcol;
    } regs_t;

    regs_t q, n;

    logic busy, xfer_done, tick, sck_sync, scs_sync, sel_ok, sdo_bit, sck_lvl;
    logic data_wr, ctrl_wr, stat_wr, data_rd, accept, collide;
    logic [DATA_W-1:0] rx_data;

    spi_port_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
        .clk(clk), .rst_n(rst_n), .d(sck_i), .q(sck_sync));

    spi_port_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scs_sync (
        .clk(clk), .rst_n(rst_n), .d(scs_i), .q(scs_sync));

    spi_port_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .run(busy && q.ctrl.master),
        .div(q.ctrl.div), .tick(tick));

    spi_port_engine #(.BITS(DATA_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .ctrl(q.ctrl),
        .load(accept && q.ctrl.en), .load_data(bus_wdata),
        .tick(tick), .sck_in(sck_sync), .sel_ok(sel_ok), .sdi(sdi_i),
        .busy(busy), .done(xfer_done), .rx_data(rx_data),
        .sck_lvl(sck_lvl), .sdo(sdo_bit));

    always_comb begin
        data_wr = bus_wr && (addr_e'(bus_addr) == ADDR_DATA);
        ctrl_wr = bus_wr && (addr_e'(bus_addr) == ADDR_CTRL);
        stat_wr = bus_wr && (addr_e'(bus_addr) == ADDR_STAT);
        data_rd = bus_rd && (addr_e'(bus_addr) == ADDR_DATA);
        accept  = data_wr && !busy;
        collide = data_wr && busy && q.ctrl.en;
        sel_ok  = !q.ctrl.cs_en || !scs_sync;
    end

    always_comb begin
        n = q;
        if (ctrl_wr) n.ctrl = ctrl_t'(bus_wdata);
        if (accept) begin
            n.data = bus_wdata;
            n.done = 1'b0;
        end
        if (data_rd) n.done = 1'b0;
        if (stat_wr && bus_wdata[STAT_WCOL]) n.wcol = 1'b0;
        if (collide) n.wcol = 1'b1;
        if (xfer_done) begin
            n.data = rx_data;
            n.done = 1'b1;
        end
        if (!q.ctrl.en) begin
            n.done = 1'b0;
            n.wcol = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    always_comb begin
        case (addr_e'(bus_addr))
            ADDR_DATA: bus_rdata = q.data;
            ADDR_CTRL: bus_rdata = q.ctrl;
            ADDR_STAT: bus_rdata = {{PAD_W{1'b0}}, q.wcol, busy, q.done};
            default:   bus_rdata = '0;
        endcase
    end

    assign sck_o  = sck_lvl;
    assign sck_oe = q.ctrl.en && q.ctrl.master;
    assign sdo_o  = sdo_bit;
    assign sdo_oe = q.ctrl.en && (q.ctrl.master || sel_ok);
    assign scs_o  = !busy;
    assign scs_oe = q.ctrl.en && q.ctrl.master && q.ctrl.cs_en;

    // R9: the collision flag holds until a clearing status write
    assert_wcol_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.wcol && q.ctrl.en && !(stat_wr && bus_wdata[STAT_WCOL])) |=> q.wcol);

    // R9: a data write during a busy shift raises the collision flag
    assert_collide_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && busy && q.ctrl.en) |=> q.wcol);

    // R11: a disabled port holds every flag at zero
    assert_disable_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !q.ctrl.en |=> (!q.done && !q.wcol && !busy));

    // R12: completion beats a same-cycle read clear
    assert_done_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> (q.done && !busy));

endmodule

// File: tb/tb_spi_port.sv
`timescale 1ns/1ps
module tb_spi_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'd0, bus_rdata;
    logic       sck_i = 1'b0, sck_o, sck_oe;
    logic       sdi_i, sdo_o, sdo_oe;
    logic       scs_i = 1'b1, scs_o, scs_oe;

    logic       s_mode = 1'b0, s_sdi = 1'b0, m_sdi;
    assign sdi_i = s_mode ? s_sdi : m_sdi;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    spi_port dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .sdi_i(sdi_i),
        .sdo_o(sdo_o), .sdo_oe(sdo_oe), .scs_i(scs_i), .scs_o(scs_o),
        .scs_oe(scs_oe));

    // external slave model used while the port is master
    logic [7:0] m_slv = 8'd0, m_cap = 8'd0;
    int         m_idx = 0;
    logic       m_prev = 1'b0, m_cpol = 1'b0, m_lsb = 1'b0;

    always @(negedge clk) begin
        if (sck_o !== m_prev) begin
            m_prev = sck_o;
            if (sck_o == m_cpol) begin
                if (m_idx < 8) m_cap[m_lsb ? m_idx : 7 - m_idx] = sdo_o;
            end else begin
                m_idx++;
            end
        end
        m_sdi = (m_idx < 8) ? m_slv[m_lsb ? m_idx : 7 - m_idx] : 1'b0;
    end

    function automatic logic [7:0] ctrl_byte(input bit en, input bit mst, input bit cpol,
                                             input bit lsb, input bit cs, input int div);
        return {en, mst, cpol, lsb, cs, 3'(div)};
    endfunction

    function automatic int busy_cycles(input int div);
        return 16 * (1 << div);
    endfunction

    task automatic check_eq(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic settle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic model_arm(input logic [7:0] slv, input bit cpol, input bit lsb);
        #1;
        m_slv = slv; m_cpol = cpol; m_lsb = lsb; m_idx = 0; m_cap = 8'd0; m_prev = sck_o;
    endtask

    task automatic wait_idle(output int cyc);
        logic [7:0] s;
        cyc = 0;
        @(negedge clk);
        peek(2'd2, s);
        while (s[1] && cyc < 5000) begin
            @(posedge clk);
            @(negedge clk);
            peek(2'd2, s);
            cyc++;
        end
    endtask

    task automatic run_master(input bit cpol, input bit lsb, input bit cs, input int div,
                              input logic [7:0] tx, input logic [7:0] slv);
        logic [7:0] s, d;
        int n;
        bit scs_bad;
        wr(2'd1, ctrl_byte(1, 1, cpol, lsb, cs, div));
        settle();
        model_arm(slv, cpol, lsb);
        check_eq("R4 idle sck level", sck_o, !cpol);
        wr(2'd0, tx);
        n = 0; scs_bad = 0;
        peek(2'd2, s);
        while (s[1] && n < 5000) begin
            n++;
            if (scs_oe !== cs || (cs && scs_o !== 1'b0)) scs_bad = 1;
            @(posedge clk);
            @(negedge clk);
            peek(2'd2, s);
        end
        check_eq("R2 busy cycle count", n, busy_cycles(div));
        check_eq("R2 complete set as busy clears", s[2:0], 3'b001);
        check_eq("R6 chip select during transfer", scs_bad, 0);
        check_eq("R6 chip select idle high", (cs ? scs_o : 1'b1), 1);
        check_eq(lsb ? "R3 sent byte lsb first" : "R3 sent byte msb first", m_cap, tx);
        check_eq("R4 sck back to idle", sck_o, !cpol);
        rd(2'd0, d);
        check_eq("R5 received byte", d, slv);
        peek(2'd2, s);
        check_eq("R10 read clears complete", s[0], 0);
    endtask

    task automatic slave_shift(input bit cpol, input bit lsb, input logic [7:0] mb,
                               output logic [7:0] cap, output bit oe_bad);
        cap = 8'd0; oe_bad = 0;
        for (int i = 0; i < 8; i++) begin
            s_sdi = lsb ? mb[i] : mb[7 - i];
            repeat (8) @(negedge clk);
            cap[lsb ? i : 7 - i] = sdo_o;
            if (sdo_oe !== 1'b1) oe_bad = 1;
            sck_i = cpol;
            repeat (8) @(negedge clk);
            sck_i = !cpol;
        end
        repeat (8) @(negedge clk);
    endtask

    task automatic run_slave(input bit cpol, input bit lsb, input bit cs,
                             input logic [7:0] tx, input logic [7:0] mb);
        logic [7:0] cap, s, d;
        bit oe_bad;
        s_mode = 1'b1;
        sck_i = !cpol;
        scs_i = 1'b1;
        wr(2'd1, ctrl_byte(1, 0, cpol, lsb, cs, 0));
        repeat (4) settle();
        wr(2'd0, tx);
        if (cs) scs_i = 1'b0;
        slave_shift(cpol, lsb, mb, cap, oe_bad);
        peek(2'd2, s);
        check_eq("R7 slave complete", s[2:0], 3'b001);
        check_eq("R7 slave sent byte", cap, tx);
        check_eq("R7 slave drives sdo when selected", oe_bad, 0);
        rd(2'd0, d);
        check_eq("R7 slave received byte", d, mb);
        scs_i = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] s, d, cap;
        int cyc, seed;
        bit oe_bad;
        seed = $urandom(32'd2718);

        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        settle();

        // R1 reset state
        peek(2'd0, d); check_eq("R1 data reset", d, 0);
        peek(2'd1, d); check_eq("R1 control reset", d, 0);
        peek(2'd2, d); check_eq("R1 status reset", d, 0);
        check_eq("R1 output enables off", {sck_oe, sdo_oe, scs_oe}, 0);

        // R2 R3 R4 R5 R6: directed then random master transfers
        run_master(1, 0, 1, 0, 8'hA5, 8'h3C);
        run_master(0, 1, 0, 2, 8'h81, 8'h7E);
        for (int k = 0; k < 6; k++) begin
            run_master($urandom % 2, $urandom % 2, $urandom % 2, $urandom % 3,
                       8'($urandom), 8'($urandom));
        end

        // R9 R12: data write landing on the completion edge
        wr(2'd1, ctrl_byte(1, 1, 1, 0, 0, 1));
        settle();
        model_arm(8'hC3, 1, 0);
        wr(2'd0, 8'h96);
        repeat (busy_cycles(1) - 1) @(posedge clk);
        @(negedge clk);
        bus_addr = 2'd0; bus_wdata = 8'h5A; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
        peek(2'd2, s);
        check_eq("R12 write at completion: wcol and complete", s[2:0], 3'b101);
        check_eq("R9 shift unaffected by late write", m_cap, 8'h96);
        rd(2'd0, d);
        check_eq("R9 colliding byte discarded", d, 8'hC3);
        wr(2'd2, 8'h04);
        peek(2'd2, s);
        check_eq("R9 wcol cleared by status write", s[2], 0);

        // R12: data read landing on the completion edge
        settle();
        model_arm(8'h0F, 1, 0);
        wr(2'd0, 8'hF0);
        repeat (busy_cycles(1) - 1) @(posedge clk);
        @(negedge clk);
        bus_addr = 2'd0; bus_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
        peek(2'd2, s);
        check_eq("R12 read at completion keeps complete", s[2:0], 3'b001);
        rd(2'd0, d);
        check_eq("R5 byte after read race", d, 8'h0F);

        // R9 mid-transfer collision, sticky across completion
        settle();
        model_arm(8'h66, 1, 0);
        wr(2'd0, 8'h2D);
        repeat (5) settle();
        wr(2'd0, 8'hFF);
        peek(2'd2, s);
        check_eq("R9 collision mid transfer", s[2:1], 2'b11);
        wait_idle(cyc);
        peek(2'd2, s);
        check_eq("R9 wcol sticky after completion", s[2:0], 3'b101);
        check_eq("R9 shift unaffected by mid write", m_cap, 8'h2D);
        rd(2'd0, d);
        check_eq("R9 received byte after collision", d, 8'h66);
        wr(2'd2, 8'h00);
        peek(2'd2, s);
        check_eq("R9 status write of 0 keeps wcol", s[2], 1);

        // R10: accepted data write clears complete
        settle();
        model_arm(8'h11, 1, 0);
        wr(2'd0, 8'h22);
        wait_idle(cyc);
        model_arm(8'h33, 1, 0);
        wr(2'd0, 8'h44);
        peek(2'd2, s);
        check_eq("R10 write clears complete and starts", s[1:0], 2'b10);

        // R11: disable mid transfer with wcol set
        wr(2'd0, 8'h55);
        wr(2'd1, ctrl_byte(0, 1, 1, 0, 1, 1));
        settle();
        peek(2'd2, s);
        check_eq("R11 flags cleared on disable", s, 0);
        check_eq("R11 outputs tri-stated", {sck_oe, sdo_oe, scs_oe}, 0);

        // R7 slave transfers
        run_slave(1, 0, 1, 8'hB4, 8'h4B);
        run_slave(0, 1, 0, 8'h19, 8'hE2);
        run_slave($urandom % 2, $urandom % 2, 1, 8'($urandom), 8'($urandom));

        // R8: deselected slave ignores edges, then chip select ignored when disabled
        s_mode = 1'b1;
        sck_i = 1'b0;
        scs_i = 1'b1;
        wr(2'd1, ctrl_byte(1, 0, 1, 0, 1, 0));
        repeat (4) settle();
        wr(2'd0, 8'hC9);
        check_eq("R8 sdo off while deselected", sdo_oe, 0);
        slave_shift(1, 0, 8'h00, cap, oe_bad);
        peek(2'd2, s);
        check_eq("R8 edges ignored while deselected", s[2:0], 3'b000);
        wr(2'd1, ctrl_byte(1, 0, 1, 0, 0, 0));
        settle();
        slave_shift(1, 0, 8'h5C, cap, oe_bad);
        check_eq("R8 loaded byte intact and sent with select ignored", cap, 8'hC9);
        peek(2'd2, s);
        check_eq("R8 complete with select ignored", s[0], 1);
        rd(2'd0, d);
        check_eq("R8 received with select ignored", d, 8'h5C);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule